// File: doc/BRIEF.md
# SDRAM Read Latency and Byte-Mask Data Pipeline

This block sits between the cell array of a 16-bit synchronous DRAM and its data pins. Beats of read data arrive from the array in consecutive clocks. The block holds each beat for a programmable number of clocks, from one to three, and then loads it into the registered output stage. The output stage drives the data and one output enable per byte. Each beat keeps the latency that was in force when its burst began. A later change to the latency therefore applies only to reads that start afterwards.

Two byte-mask inputs act on both directions. On the read side, a mask sampled at one clock edge blanks its byte in the output load two edges later, whatever the latency. On the write side, a mask blanks its byte in the same edge that captures the write data. A precharge that truncates a read burst removes the beats still in flight. The cut-off comes one edge after the precharge at latency 1 and two edges after it at latency 2 or 3. A clock-suspend input freezes every register for the edge at which it is high.

Top module: `sdram_dq_pipe`

## Requirements
- R1: While `rst` is high at an edge, every output register is cleared to zero. The latency register then selects 2 clocks.
- R2: The latency code on `lat_code[2:0]` is loaded at an edge where `lat_wr` is high. Code 3'b001 selects 1 clock, 3'b010 selects 2 and 3'b011 selects 3. A beat sampled with `rd_vld` at edge n is presented on `dq_out` after edge n+L.
- R3: A `lat_wr` carrying any other code (000, 1xx) leaves the latency unchanged.
- R4: A burst starts at a beat with `rd_first` high. All beats of that burst use the latency in force before that edge. A latency write at the same edge or later affects only bursts that start afterwards.
- R5: `dqm[1]` covers `dq_out[15:8]` and `dqm[0]` covers `dq_out[7:0]`. A mask bit high at edge m clears that byte's `dq_oe` bit in the output load at edge m+2, at any latency. A byte whose `dq_oe` bit is low reads as zero.
- R6: At each edge, `wr_be[b]` is loaded with `wr_vld` AND NOT `dqm[b]`, and `wr_dat` is loaded with `wr_data`.
- R7: A `pre_cut` pulse at edge p drops the beat sampled at p. It also suppresses any earlier beat whose output load would fall at or after edge p+1 (latency 1) or p+2 (latency 2 or 3).
- R8: An edge at which `susp` is high changes no register, so outputs, pipeline, masks and the latency register all hold. A latency write at that edge is lost.
- R9: `dq_oe` is zero in any output load that has no beat due, such as after the end of a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| susp | input | 1 | Clock suspend: the edge is ignored |
| lat_wr | input | 1 | Load the latency code |
| lat_code | input | 3 | Latency code (001, 010, 011 valid) |
| rd_vld | input | 1 | A read beat from the array is present |
| rd_first | input | 1 | The beat is the first of a burst |
| rd_data | input | 16 | Read beat from the array |
| pre_cut | input | 1 | Precharge interrupts the current read |
| dqm | input | 2 | Byte masks, bit 1 upper, bit 0 lower |
| wr_vld | input | 1 | Write data present on `wr_data` |
| wr_data | input | 16 | Write data from the pins |
| dq_out | output | 16 | Registered read data toward the pins |
| dq_oe | output | 2 | Per-byte output enable |
| wr_dat | output | 16 | Registered write data toward the array |
| wr_be | output | 2 | Per-byte write enable |

## Verification
A beat whose latency tag is wrong appears on `dq_out` one or two edges off its slot. It shows up at the first output load of the burst, as a missing or doubled word. A slip in the mask delay line moves the blanked byte to the neighbouring load, so a single-cycle mask pattern exposes it within three edges. A precharge kill window that is too long or too short leaves one beat too many or too few right after the cut. Suspend errors appear as outputs that change across the held edge.

// File: rtl/dqp_pkg.sv
package dqp_pkg;
  localparam int LAT_W   = 2;
  localparam int LAT_MAX = 3;

  typedef logic [LAT_W-1:0] lat_t;

  // Decode the mode field; zero marks a reserved code.
  function automatic lat_t code_to_lat(input logic [2:0] code);
    case (code)
      3'b001:  return lat_t'(1);
      3'b010:  return lat_t'(2);
      3'b011:  return lat_t'(3);
      default: return lat_t'(0);
    endcase
  endfunction

  // Edges after a precharge from which no output load may occur.
  function automatic int cut_gap(input lat_t lat);
    return (lat == lat_t'(1)) ? 1 : 2;
  endfunction
endpackage

// File: rtl/dqp_latreg.sv
module dqp_latreg
  import dqp_pkg::*;
#(
  parameter int RST_LAT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       susp,
  input  logic       lat_wr,
  input  logic [2:0] lat_code,
  input  logic       rd_vld,
  input  logic       rd_first,
  output lat_t       beat_lat
);
  lat_t lat_q, burst_q, dec;

  assign dec = code_to_lat(lat_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q   <= lat_t'(RST_LAT);
      burst_q <= lat_t'(RST_LAT);
    end else if (!susp) begin
      if (lat_wr && dec != '0) lat_q <= dec;
      if (rd_vld && rd_first)  burst_q <= lat_q;
    end
  end

  assign beat_lat = rd_first ? lat_q : burst_q;
endmodule

// File: rtl/dqp_stages.sv
module dqp_stages
  import dqp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = LAT_MAX
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          susp,
  input  logic          in_vld,
  input  lat_t          in_lat,
  input  logic [DW-1:0] in_data,
  input  logic          cut,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  logic [DEPTH-1:0] v_q;
  lat_t             l_q [DEPTH];
  logic [DW-1:0]    d_q [DEPTH];
  logic [DEPTH-1:0] due;

  // Stage k holds a beat sampled k+1 edges ago; it is due when its tag says so.
  for (genvar k = 0; k < DEPTH; k++) begin : g_due
    assign due[k] = v_q[k] && (l_q[k] == lat_t'(k + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else if (!susp) begin
      v_q[0] <= in_vld && !cut;
      for (int k = 1; k < DEPTH; k++)
        v_q[k] <= v_q[k-1] &&
                  !(cut && ((int'(l_q[k-1]) - k) >= cut_gap(l_q[k-1])));
    end
  end

  always_ff @(posedge clk) begin
    if (!susp) begin
      l_q[0] <= in_lat;
      d_q[0] <= in_data;
      for (int k = 1; k < DEPTH; k++) begin
        l_q[k] <= l_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  // Shortest age wins if two beats collide.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (due[k]) begin
        hit      = 1'b1;
        hit_data = d_q[k];
      end
    end
  end
endmodule

// File: rtl/dqp_maskdly.sv
module dqp_maskdly #(
  parameter int NB  = 2,
  parameter int DLY = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          susp,
  input  logic [NB-1:0] m_in,
  output logic [NB-1:0] m_due
);
  logic [NB-1:0] sh [DLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DLY; i++) sh[i] <= '0;
    end else if (!susp) begin
      sh[0] <= m_in;
      for (int i = 1; i < DLY; i++) sh[i] <= sh[i-1];
    end
  end

  assign m_due = sh[DLY-1];
endmodule

// File: rtl/dqp_wrmask.sv
module dqp_wrmask #(
  parameter int DW = 16,
  parameter int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          susp,
  input  logic          wr_vld,
  input  logic [DW-1:0] wr_data,
  input  logic [NB-1:0] dqm,
  output logic [DW-1:0] wr_dat,
  output logic [NB-1:0] wr_be
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_dat <= '0;
      wr_be  <= '0;
    end else if (!susp) begin
      wr_dat <= wr_data;
      wr_be  <= {NB{wr_vld}} & ~dqm;
    end
  end
endmodule

// File: rtl/sdram_dq_pipe.sv
module sdram_dq_pipe
  import dqp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int MASK_DLY = 2,
  parameter int RST_LAT  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             susp,
  input  logic             lat_wr,
  input  logic [2:0]       lat_code,
  input  logic             rd_vld,
  input  logic             rd_first,
  input  logic [DW-1:0]    rd_data,
  input  logic             pre_cut,
  input  logic [DW/8-1:0]  dqm,
  input  logic             wr_vld,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    dq_out,
  output logic [DW/8-1:0]  dq_oe,
  output logic [DW-1:0]    wr_dat,
  output logic [DW/8-1:0]  wr_be
);
  localparam int NB = DW / 8;

  lat_t          beat_lat;
  logic          hit;
  logic [DW-1:0] hit_data;
  logic [NB-1:0] m_due;
  logic [NB-1:0] byte_en;

  dqp_latreg #(.RST_LAT(RST_LAT)) u_lat (
    .clk(clk), .rst(rst), .susp(susp), .lat_wr(lat_wr), .lat_code(lat_code),
    .rd_vld(rd_vld), .rd_first(rd_first), .beat_lat(beat_lat)
  );

  dqp_stages #(.DW(DW), .DEPTH(LAT_MAX)) u_stg (
    .clk(clk), .rst(rst), .susp(susp), .in_vld(rd_vld), .in_lat(beat_lat),
    .in_data(rd_data), .cut(pre_cut), .hit(hit), .hit_data(hit_data)
  );

  dqp_maskdly #(.NB(NB), .DLY(MASK_DLY)) u_msk (
    .clk(clk), .rst(rst), .susp(susp), .m_in(dqm), .m_due(m_due)
  );

  dqp_wrmask #(.DW(DW), .NB(NB)) u_wr (
    .clk(clk), .rst(rst), .susp(susp), .wr_vld(wr_vld), .wr_data(wr_data),
    .dqm(dqm), .wr_dat(wr_dat), .wr_be(wr_be)
  );

  assign byte_en = {NB{hit}} & ~m_due;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else if (!susp) begin
      dq_oe <= byte_en;
      for (int b = 0; b < NB; b++)
        dq_out[b*8 +: 8] <= byte_en[b] ? hit_data[b*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/dqp_chk.sv
module dqp_chk #(
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             susp,
  input logic             rd_vld,
  input logic [DW/8-1:0]  dqm,
  input logic             wr_vld,
  input logic [DW-1:0]    dq_out,
  input logic [DW/8-1:0]  dq_oe,
  input logic [DW-1:0]    wr_dat,
  input logic [DW/8-1:0]  wr_be
);
  localparam int NB = DW / 8;
  logic [2:0] gcnt;

  always_ff @(posedge clk) begin
    if (rst) gcnt <= '0;
    else if (gcnt != 3'd4) gcnt <= gcnt + 3'd1;
  end

  // R5: mask sampled two processed edges before the load blanks the byte
  assert_rdmask_R5: assert property (@(posedge clk) disable iff (rst)
    (gcnt == 3'd4 && !$past(susp) && !$past(susp, 2) && !$past(susp, 3))
      |-> ((dq_oe & $past(dqm, 3)) == '0));

  // R5: a disabled byte carries zero
  for (genvar b = 0; b < NB; b++) begin : g_zero
    assert_offzero_R5: assert property (@(posedge clk) disable iff (rst)
      (!dq_oe[b]) |-> (dq_out[b*8 +: 8] == 8'h00));
  end

  // R6: write enable never set for a masked byte or without write data
  assert_wrmask_R6: assert property (@(posedge clk) disable iff (rst)
    (gcnt >= 3'd1 && !$past(susp))
      |-> ((wr_be & ($past(dqm) | {NB{!$past(wr_vld)}})) == '0));

  // R8: a suspended edge changes no output
  assert_susp_R8: assert property (@(posedge clk) disable iff (rst)
    (gcnt >= 3'd2 && $past(susp))
      |-> ($stable(dq_out) && $stable(dq_oe) && $stable(wr_be) && $stable(wr_dat)));

  // R9: with no beat sampled in the last three edges the bus is off
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (gcnt == 3'd4 && !$past(susp) && !$past(susp, 2) && !$past(susp, 3) &&
     !$past(rd_vld, 2) && !$past(rd_vld, 3) && !$past(rd_vld, 4))
      |-> (dq_oe == '0));
endmodule

bind sdram_dq_pipe dqp_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .susp(susp), .rd_vld(rd_vld), .dqm(dqm),
  .wr_vld(wr_vld), .dq_out(dq_out), .dq_oe(dq_oe), .wr_dat(wr_dat), .wr_be(wr_be)
);

// File: tb/sdram_dq_pipe_test.sv
module sdram_dq_pipe_test;
  logic        clk = 1'b0;
  logic        rst, susp, lat_wr, rd_vld, rd_first, pre_cut, wr_vld;
  logic [2:0]  lat_code;
  logic [15:0] rd_data, wr_data;
  logic [1:0]  dqm;
  logic [15:0] dq_out, wr_dat;
  logic [1:0]  dq_oe, wr_be;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sdram_dq_pipe uut (
    .clk(clk), .rst(rst), .susp(susp), .lat_wr(lat_wr), .lat_code(lat_code),
    .rd_vld(rd_vld), .rd_first(rd_first), .rd_data(rd_data), .pre_cut(pre_cut),
    .dqm(dqm), .wr_vld(wr_vld), .wr_data(wr_data),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_dat(wr_dat), .wr_be(wr_be)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle_inputs;
    susp = 0; lat_wr = 0; lat_code = 3'b000; rd_vld = 0; rd_first = 0;
    rd_data = 16'h0; pre_cut = 0; dqm = 2'b00; wr_vld = 0; wr_data = 16'h0;
  endtask

  function automatic logic [15:0] beat(input logic [15:0] base, input int c);
    return base ^ (16'h1111 * 16'(c));
  endfunction

  // One read burst with per-cycle masks, optional cut and optional latency write.
  task automatic run_read(input logic [2:0] set_code, input int lat, input int n,
                          input int cut, input logic [15:0] mlo, input logic [15:0] mhi,
                          input logic [15:0] base, input int chg_at,
                          input logic [2:0] chg_code, input string rq);
    int gap;
    gap = (lat == 1) ? 1 : 2;
    if (set_code != 3'b000) begin
      lat_wr = 1; lat_code = set_code; tick; lat_wr = 0;
    end
    for (int c = 0; c < n + 6; c++) begin
      int j;
      logic vld;
      logic [1:0] mb, eoe;
      logic [15:0] ed;
      rd_vld   = (cut < 0) ? (c < n) : (c <= cut && c < n);
      rd_first = (c == 0);
      rd_data  = beat(base, c);
      dqm      = {mhi[c], mlo[c]};
      pre_cut  = (c == cut);
      lat_wr   = (c == chg_at);
      lat_code = chg_code;
      tick;
      j   = c - lat;
      vld = (j >= 0) && (j < n) && ((cut < 0) || (j <= cut && c < cut + gap));
      mb  = (c >= 2) ? {mhi[c-2], mlo[c-2]} : 2'b00;
      eoe = vld ? ~mb : 2'b00;
      ed  = beat(base, j);
      ed  = {eoe[1] ? ed[15:8] : 8'h00, eoe[0] ? ed[7:0] : 8'h00};
      chk(rq, {30'd0, dq_oe}, {30'd0, eoe});
      chk(rq, {16'd0, dq_out}, {16'd0, ed});
    end
    idle_inputs;
  endtask

  task automatic t_reset;
    chk("R1 reset dq_out", {16'd0, dq_out}, 32'd0);
    chk("R1 reset dq_oe", {30'd0, dq_oe}, 32'd0);
    chk("R1 reset wr_be", {30'd0, wr_be}, 32'd0);
    chk("R1 reset wr_dat", {16'd0, wr_dat}, 32'd0);
    run_read(3'b000, 2, 2, -1, 16'h0, 16'h0, 16'hA5C3, -1, 3'b000, "R1 default latency 2");
  endtask

  task automatic t_latency;
    run_read(3'b001, 1, 4, -1, 16'h0, 16'h0, 16'h1234, -1, 3'b000, "R2 latency 1");
    run_read(3'b010, 2, 4, -1, 16'h0, 16'h0, 16'h5678, -1, 3'b000, "R2 latency 2");
    run_read(3'b011, 3, 4, -1, 16'h0, 16'h0, 16'h9ABC, -1, 3'b000, "R2 R9 latency 3");
  endtask

  task automatic t_rdmask;
    run_read(3'b001, 1, 6, -1, 16'b0000_0000_0001_0100, 16'b0000_0000_0000_1100,
             16'hC0DE, -1, 3'b000, "R5 mask lat1");
    run_read(3'b011, 3, 6, -1, 16'b0000_0000_0010_1000, 16'b0000_0000_0011_0000,
             16'hBEEF, -1, 3'b000, "R5 mask lat3");
  endtask

  task automatic t_cut;
    run_read(3'b001, 1, 8, 3, 16'h0, 16'h0, 16'h0F0F, -1, 3'b000, "R7 cut lat1");
    run_read(3'b010, 2, 8, 3, 16'h0, 16'h0, 16'h3C3C, -1, 3'b000, "R7 cut lat2");
    run_read(3'b011, 3, 8, 3, 16'h0, 16'h0, 16'h6969, -1, 3'b000, "R7 cut lat3");
  endtask

  task automatic t_latchange;
    run_read(3'b001, 1, 4, -1, 16'h0, 16'h0, 16'h2468, 1, 3'b011, "R4 burst keeps lat1");
    run_read(3'b000, 3, 4, -1, 16'h0, 16'h0, 16'h1357, -1, 3'b000, "R4 next burst lat3");
  endtask

  task automatic t_reserved;
    lat_wr = 1;
    lat_code = 3'b000; tick;
    lat_code = 3'b111; tick;
    lat_code = 3'b100; tick;
    lat_wr = 0;
    run_read(3'b000, 3, 3, -1, 16'h0, 16'h0, 16'h7E7E, -1, 3'b000, "R3 reserved ignored");
  endtask

  task automatic t_susp;
    lat_wr = 1; lat_code = 3'b010; tick; lat_wr = 0;
    rd_vld = 1; rd_first = 1; rd_data = 16'hAAAA; wr_vld = 1; wr_data = 16'h1111; tick;
    chk("R8 pre wr_be", {30'd0, wr_be}, 32'd3);
    rd_first = 0; rd_data = 16'hBBCC; wr_data = 16'h2222; dqm = 2'b01; tick;
    chk("R6 R8 wr_be masked", {30'd0, wr_be}, 32'd2);
    rd_vld = 0; wr_vld = 0; dqm = 2'b00; susp = 1; lat_wr = 1; lat_code = 3'b001; tick;
    susp = 0; lat_wr = 0;
    chk("R8 held wr_be", {30'd0, wr_be}, 32'd2);
    chk("R8 held wr_dat", {16'd0, wr_dat}, 32'h2222);
    chk("R8 held dq_oe", {30'd0, dq_oe}, 32'd0);
    tick;
    chk("R8 beat0 oe", {30'd0, dq_oe}, 32'd3);
    chk("R8 beat0 data", {16'd0, dq_out}, 32'hAAAA);
    tick;
    chk("R8 R5 beat1 oe", {30'd0, dq_oe}, 32'd2);
    chk("R8 R5 beat1 data", {16'd0, dq_out}, 32'hBB00);
    tick;
    chk("R9 drained", {30'd0, dq_oe}, 32'd0);
    run_read(3'b000, 2, 2, -1, 16'h0, 16'h0, 16'h4321, -1, 3'b000, "R8 latency write lost");
  endtask

  task automatic t_write;
    logic [1:0] pm [5];
    logic       pv [5];
    pm[0] = 2'b00; pv[0] = 1;
    pm[1] = 2'b10; pv[1] = 1;
    pm[2] = 2'b11; pv[2] = 1;
    pm[3] = 2'b00; pv[3] = 0;
    pm[4] = 2'b01; pv[4] = 1;
    for (int i = 0; i < 5; i++) begin
      wr_vld = pv[i]; dqm = pm[i]; wr_data = 16'h0F00 + 16'(i);
      tick;
      chk("R6 wr_be", {30'd0, wr_be}, {30'd0, (pv[i] ? ~pm[i] : 2'b00)});
      chk("R6 wr_dat", {16'd0, wr_dat}, {16'd0, 16'h0F00 + 16'(i)});
    end
    idle_inputs;
    tick;
  endtask

  initial begin
    idle_inputs;
    rst = 1;
    repeat (3) tick;
    rst = 0;
    t_reset;
    t_latency;
    t_rdmask;
    t_cut;
    t_latchange;
    t_reserved;
    t_susp;
    t_write;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule